// File: doc/BRIEF.md
# Per-Line Interrupt Sense Bank

This block watches 32 serial-GPIO input lines, whose values arrive as one sampled word per serial frame. On each new sample it checks every line against a trigger mode chosen for that line. The mode can be rising edge, falling edge, both edges, level high or level low. A line that matches and is enabled sets its own sticky status bit.

A host reaches the bank through a small word-wide register port. There are five registers:

- a per-line enable mask;
- three parallel type registers that together encode each line's trigger mode;
- a status register that the host clears by writing ones.

A single interrupt output is raised while any enabled line holds a status bit. The host then reads status, serves the lines that are set and writes those bits back to clear them.

The block sees samples only through a one-cycle strobe. The bank never looks at the lines between strobes. Each edge is judged against the sample of the same line taken at the previous strobe.

Top module: `irq_sense_bank`

## Requirements
- R1: After a synchronous reset the registers read back as follows: enable all 0, type0 all 1, type1 all 1, type2 all 0, status all 0. The interrupt output is 0 and the stored previous sample is all 0.
- R2: The register offsets are 0x00 enable, 0x04 type0, 0x08 type1, 0x0C type2 and 0x10 status. A read returns, one clock after the address is presented, the value held before any write in that same cycle. Any other offset reads as 0 and a write to it changes nothing.
- R3: Each line's mode is taken from the bits of its own position. type2=1 selects both edges whatever type0 and type1 hold. Otherwise the pair {type1,type0} selects: 00 falling edge, 01 rising edge, 10 level low, 11 level high.
- R4: Detection happens only in a cycle where the sample strobe is high. An edge is a difference between the new sample and the sample of the same line at the previous strobe.
- R5: A detection sets a status bit only when that line's enable bit was 1 before the cycle.
- R6: Writing to status clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R7: In a level mode the status bit is set again on every strobe for as long as the level holds, even right after a clear. In an edge mode a repeated, unchanged sample sets nothing.
- R8: The interrupt output equals the OR over all lines of (status AND enable). It is registered and changes on the same clock edge as those registers. Clearing an enable masks the interrupt but keeps the status bit.
- R9: When a status clear write and a detection hit the same line in the same cycle, the status bit ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | One-cycle strobe: a new frame sample is on smp_data |
| smp_data | input | LINES | Sampled line values |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset (read and write) |
| reg_wdata | input | LINES | Register write data |
| reg_rdata | output | LINES | Registered read data for reg_addr |
| irq | output | 1 | Combined interrupt, registered |

## Verification
The two functions that can collide are the host's write-one-to-clear of status and the setting of that same status bit by a detection. The bench provokes this case in two steps. First it leaves line 0 set through a rising edge in rising mode. Then it drives a new rising sample on that line in the very cycle that writes 1 to its status bit. It then reads status back and expects the bit set, as R9 requires. As a control, a clear issued with no sample in the same cycle must leave the bit at 0.

// File: rtl/irq_sense_pkg.sv
package irq_sense_pkg;

  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] OFS_ENABLE = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_TYPE0  = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_TYPE1  = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_TYPE2  = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_STATUS = 5'h10;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_ENABLE,
    SEL_TYPE0,
    SEL_TYPE1,
    SEL_TYPE2,
    SEL_STATUS
  } reg_sel_e;

  function automatic reg_sel_e decode_ofs(input logic [ADDR_W-1:0] ofs);
    case (ofs)
      OFS_ENABLE: return SEL_ENABLE;
      OFS_TYPE0:  return SEL_TYPE0;
      OFS_TYPE1:  return SEL_TYPE1;
      OFS_TYPE2:  return SEL_TYPE2;
      OFS_STATUS: return SEL_STATUS;
      default:    return SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/irq_trig_detect.sv
module irq_trig_detect #(
  parameter int LINES = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smp_valid,
  input  logic [LINES-1:0] smp_data,
  input  logic [LINES-1:0] type0,
  input  logic [LINES-1:0] type1,
  input  logic [LINES-1:0] type2,
  output logic [LINES-1:0] hit
);

  // Sample seen at the previous strobe, per line (R4)
  logic [LINES-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst)            prev_q <= '0;
    else if (smp_valid) prev_q <= smp_data;
  end

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic rise, fall, match;
    always_comb begin
      rise = smp_data[g] & ~prev_q[g];
      fall = ~smp_data[g] & prev_q[g];
      if (type2[g]) begin
        match = rise | fall;
      end else begin
        case ({type1[g], type0[g]})
          2'b00:   match = fall;
          2'b01:   match = rise;
          2'b10:   match = ~smp_data[g];
          default: match = smp_data[g];
        endcase
      end
    end
    assign hit[g] = smp_valid & match;
  end

  // R4: a line whose sample did not change cannot produce an edge hit
  a_r4_edge_needs_change: assert property (@(posedge clk) disable iff (rst)
    ((hit & ~type1 & ~(smp_data ^ prev_q)) == '0));

endmodule

// File: rtl/irq_bank_regs.sv
module irq_bank_regs import irq_sense_pkg::*; #(
  parameter int LINES = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [LINES-1:0]  reg_wdata,
  input  logic [LINES-1:0]  hit,
  output logic [LINES-1:0]  en_q,
  output logic [LINES-1:0]  t0_q,
  output logic [LINES-1:0]  t1_q,
  output logic [LINES-1:0]  t2_q,
  output logic [LINES-1:0]  stat_q,
  output logic [LINES-1:0]  en_d,
  output logic [LINES-1:0]  stat_d,
  output logic [LINES-1:0]  reg_rdata
);

  reg_sel_e         sel;
  logic [LINES-1:0] clr;
  logic [LINES-1:0] set;

  always_comb begin
    sel    = decode_ofs(reg_addr);
    en_d   = (reg_wr && sel == SEL_ENABLE) ? reg_wdata : en_q;
    clr    = (reg_wr && sel == SEL_STATUS) ? reg_wdata : '0;
    set    = hit & en_q;
    // detection is ORed after the clear, so it wins (R9)
    stat_d = (stat_q & ~clr) | set;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q      <= '0;
      t0_q      <= '1;
      t1_q      <= '1;
      t2_q      <= '0;
      stat_q    <= '0;
      reg_rdata <= '0;
    end else begin
      en_q   <= en_d;
      stat_q <= stat_d;
      if (reg_wr && sel == SEL_TYPE0) t0_q <= reg_wdata;
      if (reg_wr && sel == SEL_TYPE1) t1_q <= reg_wdata;
      if (reg_wr && sel == SEL_TYPE2) t2_q <= reg_wdata;
      case (sel)
        SEL_ENABLE: reg_rdata <= en_q;
        SEL_TYPE0:  reg_rdata <= t0_q;
        SEL_TYPE1:  reg_rdata <= t1_q;
        SEL_TYPE2:  reg_rdata <= t2_q;
        SEL_STATUS: reg_rdata <= stat_q;
        default:    reg_rdata <= '0;
      endcase
    end
  end

  // R1: reset values
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (en_q == '0 && t0_q == '1 && t1_q == '1 && t2_q == '0 && stat_q == '0));

  // R5: a status bit cannot rise on a line that was disabled
  a_r5_masked_no_set: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(en_q)) == '0));

  // R6: bits written as one are clear afterwards unless a detection hit them
  a_r6_w1c: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && sel == SEL_STATUS) |=> ((stat_q & $past(reg_wdata) & ~$past(hit & en_q)) == '0));

  // R9: every enabled hit leaves its status bit set
  a_r9_hit_sets: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(hit & en_q) & ~stat_q) == '0));

endmodule

// File: rtl/irq_sense_bank.sv
module irq_sense_bank import irq_sense_pkg::*; #(
  parameter int LINES = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_valid,
  input  logic [LINES-1:0]  smp_data,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [LINES-1:0]  reg_wdata,
  output logic [LINES-1:0]  reg_rdata,
  output logic              irq
);

  logic [LINES-1:0] hit;
  logic [LINES-1:0] en_q, t0_q, t1_q, t2_q, stat_q, en_d, stat_d;

  irq_trig_detect #(.LINES(LINES)) u_detect (
    .clk       (clk),
    .rst       (rst),
    .smp_valid (smp_valid),
    .smp_data  (smp_data),
    .type0     (t0_q),
    .type1     (t1_q),
    .type2     (t2_q),
    .hit       (hit)
  );

  irq_bank_regs #(.LINES(LINES)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .hit       (hit),
    .en_q      (en_q),
    .t0_q      (t0_q),
    .t1_q      (t1_q),
    .t2_q      (t2_q),
    .stat_q    (stat_q),
    .en_d      (en_d),
    .stat_d    (stat_d),
    .reg_rdata (reg_rdata)
  );

  // Built from next-state values so irq moves on the same edge as the registers
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(stat_d & en_d);
  end

  // R8: irq tracks the registered status and enable
  a_r8_irq_follows: assert property (@(posedge clk) disable iff (rst)
    irq == |(stat_q & en_q));

  // R4: no status bit rises in a cycle without a sample strobe
  a_r4_idle_no_set: assert property (@(posedge clk) disable iff (rst)
    !smp_valid |=> ((stat_q & ~$past(stat_q)) == '0));

endmodule

// File: tb/sim_irq_sense_bank.sv
module sim_irq_sense_bank;

  localparam int CLK_PERIOD = 10;
  localparam int LINES = 32;

  localparam logic [4:0] A_EN = 5'h00, A_T0 = 5'h04, A_T1 = 5'h08,
                         A_T2 = 5'h0C, A_ST = 5'h10;

  typedef struct packed {
    logic [31:0] en, t0, t1, t2, a, b, exp;
  } vec_t;

  // a = 0xCC, b = 0xAA: rise 0x22, fall 0x44, both 0x66
  localparam vec_t VECS [8] = '{
    '{32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0,        32'h0,        32'hCC, 32'hAA, 32'h00000022},
    '{32'hFFFFFFFF, 32'h0,        32'h0,        32'h0,        32'hCC, 32'hAA, 32'h00000044},
    '{32'hFFFFFFFF, 32'h0,        32'h0,        32'hFFFFFFFF, 32'hCC, 32'hAA, 32'h00000066},
    '{32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0,        32'hCC, 32'hAA, 32'h000000AA},
    '{32'hFFFFFFFF, 32'h0,        32'hFFFFFFFF, 32'h0,        32'hCC, 32'hAA, 32'hFFFFFF55},
    '{32'hFFFFFFFF, 32'h000000FF, 32'h000000F0, 32'h0,        32'hCC, 32'hAA, 32'h000000A2},
    '{32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hCC, 32'hAA, 32'h00000066},
    '{32'h0000000F, 32'hFFFFFFFF, 32'h0,        32'h0,        32'hCC, 32'hAA, 32'h00000002}
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             smp_valid = 1'b0;
  logic [LINES-1:0] smp_data = '0;
  logic             reg_wr = 1'b0;
  logic [4:0]       reg_addr = '0;
  logic [LINES-1:0] reg_wdata = '0;
  logic [LINES-1:0] reg_rdata;
  logic             irq;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 1'b0;
  logic [31:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_sense_bank #(.LINES(LINES)) u0 (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic smp(input logic [31:0] v);
    @(negedge clk);
    smp_valid = 1'b1; smp_data = v;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(A_EN, rv); check("R1 enable", rv, 32'h0);
    rd(A_T0, rv); check("R1 type0", rv, 32'hFFFFFFFF);
    rd(A_T1, rv); check("R1 type1", rv, 32'hFFFFFFFF);
    rd(A_T2, rv); check("R1 type2", rv, 32'h0);
    rd(A_ST, rv); check("R1 status", rv, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);

    // R2 unknown offsets ignored
    wr(5'h14, 32'hDEADBEEF);
    wr(5'h02, 32'hDEADBEEF);
    rd(5'h14, rv); check("R2 unknown reads zero", rv, 32'h0);
    rd(A_EN, rv);  check("R2 enable untouched", rv, 32'h0);
    rd(A_T0, rv);  check("R2 type0 untouched", rv, 32'hFFFFFFFF);

    // R3 R5 table of modes
    foreach (VECS[i]) begin
      wr(A_EN, VECS[i].en);
      wr(A_T0, VECS[i].t0);
      wr(A_T1, VECS[i].t1);
      wr(A_T2, VECS[i].t2);
      smp(VECS[i].a);
      wr(A_ST, 32'hFFFFFFFF);
      smp(VECS[i].b);
      rd(A_ST, rv);
      check($sformatf("R3 R5 vector %0d status", i), rv, VECS[i].exp);
      check($sformatf("R8 vector %0d irq", i), {31'b0, irq}, {31'b0, VECS[i].exp != 0});
    end

    // R6 write-one-to-clear
    wr(A_EN, 32'hFFFFFFFF); wr(A_T0, 32'hFFFFFFFF); wr(A_T1, 32'h0); wr(A_T2, 32'h0);
    smp(32'h0); wr(A_ST, 32'hFFFFFFFF);
    smp(32'h0000000F);
    rd(A_ST, rv); check("R6 setup status", rv, 32'h0000000F);
    wr(A_ST, 32'h00000005);
    rd(A_ST, rv); check("R6 clear ones only", rv, 32'h0000000A);
    wr(A_ST, 32'h0);
    rd(A_ST, rv); check("R6 zero write keeps", rv, 32'h0000000A);

    // R4 edge mode: unchanged sample sets nothing
    wr(A_ST, 32'hFFFFFFFF);
    smp(32'h0000000F);
    rd(A_ST, rv); check("R4 R7 repeated edge sample", rv, 32'h0);

    // R7 level high re-sets after clear
    wr(A_T1, 32'hFFFFFFFF);
    smp(32'h00000001);
    wr(A_ST, 32'hFFFFFFFF);
    rd(A_ST, rv); check("R7 cleared without sample", rv, 32'h0);
    smp(32'h00000001);
    rd(A_ST, rv); check("R7 level sets again", rv, 32'h00000001);

    // R8 irq masking
    check("R8 irq on", {31'b0, irq}, 32'h1);
    wr(A_EN, 32'h0);
    check("R8 irq masked", {31'b0, irq}, 32'h0);
    rd(A_ST, rv); check("R8 status kept when masked", rv, 32'h00000001);
    wr(A_EN, 32'hFFFFFFFF);
    check("R8 irq back", {31'b0, irq}, 32'h1);

    // R9 collision: rising mode, line 0 set, new rise with clear
    wr(A_ST, 32'hFFFFFFFF);
    wr(A_T1, 32'h0);
    smp(32'h0); smp(32'h1); smp(32'h0);
    rd(A_ST, rv); check("R9 setup", rv, 32'h1);
    @(negedge clk);
    smp_valid = 1'b1; smp_data = 32'h1;
    reg_wr = 1'b1; reg_addr = A_ST; reg_wdata = 32'h1;
    @(negedge clk);
    smp_valid = 1'b0; reg_wr = 1'b0;
    rd(A_ST, rv); check("R9 detection wins", rv, 32'h1);
    wr(A_ST, 32'h1);
    rd(A_ST, rv); check("R9 control clear", rv, 32'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule